// File: doc/BRIEF.md
# Selective Power-Down and Clock Output Gating

This block turns two chip-level control pins and a set of per-section configuration bits into the power and drive controls of a clock generator. It has one power-down pin and one output-enable pin. Each PLL and each post divider has its own power-down select bit, and the power-down pin acts only on the sections whose select bit is set. A section whose bit is clear keeps running while the pin is high.

When the power-down pin is high, each selected PLL and post divider gets a power-down strobe. A post divider that is powered down forces its clock output low. The reference oscillator is shut down only when every PLL and every post divider is powered down at the same time. While it is shut down, its input side is driven low and its output side is pulled high.

A low level on the output-enable pin puts all clock outputs into high impedance, and high impedance takes priority over forced-low. Both pins have pull-ups: an undriven pin reads as high. Both functions work only in run mode. In programming mode every control is inactive, so the crystal frequency passes through.

The pins pass through a two-flop synchronizer and every control output is registered. The analog oscillator, the PLLs and the pad cells sit outside this block. The block drives them through enable and force signals.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: `pll_pwrdn[j]` is 1 exactly when run mode is on, the synchronized power-down pin is high and `pll_pd_sel[j]` is 1. `div_pwrdn[i]` follows the same rule with `div_pd_sel[i]`.
- R2: When `pd_pin_drv` is 0, the power-down pin reads as high (pull-up), whatever the value on `pd_pin`.
- R3: Clock output i is fed by post divider i. `clk_force_low[i]` is 1 when divider i is powered down and the output is not tristated.
- R4: `osc_pwrdn`, `osc_in_low` and `osc_out_high` are 1 exactly when every PLL and every post divider is powered down together. They are 0 if any single section keeps running.
- R5: When the synchronized output-enable pin is low in run mode, every bit of `clk_tristate` is 1.
- R6: When `oe_pin_drv` is 0, the output-enable pin reads as high (pull-up), so the outputs stay enabled whatever the value on `oe_pin`.
- R7: Tristate has priority over forced-low: `clk_tristate[i]` and `clk_force_low[i]` are never 1 together.
- R8: With `run_mode` at 0, every output is 0, whatever the pin levels and select bits.
- R9: A change on a pin reaches the outputs on the third rising clock edge after it. A change on `run_mode` or on a select bit reaches them on the first rising edge.
- R10: While reset is asserted, and until the first update after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 1 = run mode, 0 = programming mode |
| pd_pin | input | 1 | Power-down pin level, active high |
| pd_pin_drv | input | 1 | 1 when the power-down pin is driven externally |
| oe_pin | input | 1 | Output-enable pin level, active high |
| oe_pin_drv | input | 1 | 1 when the output-enable pin is driven externally |
| pll_pd_sel | input | NUM_PLL | Per-PLL power-down select bits |
| div_pd_sel | input | NUM_OUT | Per-post-divider power-down select bits |
| pll_pwrdn | output | NUM_PLL | Power-down strobe per PLL |
| div_pwrdn | output | NUM_OUT | Power-down strobe per post divider |
| osc_pwrdn | output | 1 | Reference oscillator power-down |
| osc_in_low | output | 1 | Drive the oscillator input low |
| osc_out_high | output | 1 | Pull the oscillator output high |
| clk_force_low | output | NUM_OUT | Force clock output i low |
| clk_tristate | output | NUM_OUT | Put clock output i in high impedance |

## Verification
A fault in a synchronizer stage shows up as a pin change that arrives one edge early or late, or never arrives. The bench samples the cycle before and the cycle of the expected change. A wrong select decode shows at once as a running section that is reported down, or the reverse. A wrong oscillator term shows when all sections but one are selected. A wrong priority shows on the first cycle that has both tristate and power-down. A leak out of programming mode shows one edge after `run_mode` falls.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  // Synchronized view of the two global pins after pull-up resolution.
  typedef struct packed {
    logic pd_act;   // 1 = power-down requested
    logic oe_act;   // 1 = outputs enabled
  } glb_ctrl_t;

  // Pin index inside the synchronizer bank.
  localparam int unsigned PIN_PD   = 0;
  localparam int unsigned PIN_OE   = 1;
  localparam int unsigned NUM_PINS = 2;

  // Resolve a pad with an internal pull-up: undriven reads as high.
  function automatic logic pullup_resolve(input logic val, input logic drv);
    return drv ? val : 1'b1;
  endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync
  import pwr_gate_pkg::*;
#(
  parameter int unsigned NPINS = NUM_PINS,
  parameter int unsigned STAGES = 2,
  parameter logic [NPINS-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_val,
  input  logic [NPINS-1:0] pin_drv,
  output logic [NPINS-1:0] pin_sync
);

  localparam int unsigned LAST = STAGES - 1;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic              resolved;
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      resolved = pullup_resolve(pin_val[p], pin_drv[p]);
      chain_d  = {chain_q[STAGES-2:0], resolved};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[p]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign pin_sync[p] = chain_q[LAST];
  end

endmodule

// File: rtl/pwr_section_ctrl.sv
module pwr_section_ctrl #(
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned NUM_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_mode,
  input  logic               pd_act,
  input  logic [NUM_PLL-1:0] pll_sel,
  input  logic [NUM_DIV-1:0] div_sel,
  output logic [NUM_PLL-1:0] pll_pwrdn,
  output logic [NUM_DIV-1:0] div_pwrdn,
  output logic               osc_pwrdn,
  output logic               osc_in_low,
  output logic               osc_out_high
);

  logic               gate_en;
  logic [NUM_PLL-1:0] pll_d, pll_q;
  logic [NUM_DIV-1:0] div_d, div_q;
  logic               osc_d, osc_q;
  logic               all_down;

  always_comb begin
    gate_en  = run_mode & pd_act;
    pll_d    = gate_en ? pll_sel : '0;
    div_d    = gate_en ? div_sel : '0;
    all_down = (&pll_d) & (&div_d);
    osc_d    = gate_en & all_down;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_q <= '0;
      div_q <= '0;
      osc_q <= 1'b0;
    end else begin
      pll_q <= pll_d;
      div_q <= div_d;
      osc_q <= osc_d;
    end
  end

  assign pll_pwrdn    = pll_q;
  assign div_pwrdn    = div_q;
  assign osc_pwrdn    = osc_q;
  assign osc_in_low   = osc_q;
  assign osc_out_high = osc_q;

  // R4: oscillator down implies every section down in the same cycle
  assert_osc_all_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    osc_pwrdn |-> ((&pll_pwrdn) && (&div_pwrdn)));

  // R4: every section down implies oscillator down
  assert_osc_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((&pll_pwrdn) && (&div_pwrdn)) |-> osc_pwrdn);

  // R1: a section only powers down if it was selected on the previous edge
  assert_pll_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) or ((pll_pwrdn & ~$past(pll_sel)) == '0));

endmodule

// File: rtl/pwr_out_gate.sv
module pwr_out_gate #(
  parameter int unsigned NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_mode,
  input  logic               pd_act,
  input  logic               oe_act,
  input  logic [NUM_OUT-1:0] div_sel,
  output logic [NUM_OUT-1:0] force_low,
  output logic [NUM_OUT-1:0] tristate
);

  logic run_pd;
  logic run_off;

  always_comb begin
    run_pd  = run_mode & pd_act;
    run_off = run_mode & ~oe_act;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic fl_d, fl_q;
    logic ts_d, ts_q;

    always_comb begin
      ts_d = run_off;
      fl_d = run_pd & div_sel[i] & ~ts_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fl_q <= 1'b0;
        ts_q <= 1'b0;
      end else begin
        fl_q <= fl_d;
        ts_q <= ts_d;
      end
    end

    assign force_low[i] = fl_q;
    assign tristate[i]  = ts_q;

    // R7: high impedance and forced-low never together
    assert_tri_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tristate[i] && force_low[i]));
  end

  // R5: outputs tristate together
  assert_tri_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tristate == '0) || (&tristate));

endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl
  import pwr_gate_pkg::*;
#(
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_mode,
  input  logic               pd_pin,
  input  logic               pd_pin_drv,
  input  logic               oe_pin,
  input  logic               oe_pin_drv,
  input  logic [NUM_PLL-1:0] pll_pd_sel,
  input  logic [NUM_OUT-1:0] div_pd_sel,
  output logic [NUM_PLL-1:0] pll_pwrdn,
  output logic [NUM_OUT-1:0] div_pwrdn,
  output logic               osc_pwrdn,
  output logic               osc_in_low,
  output logic               osc_out_high,
  output logic [NUM_OUT-1:0] clk_force_low,
  output logic [NUM_OUT-1:0] clk_tristate
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_q[1];

  // Reset value of pins: inactive (no power-down, outputs enabled).
  localparam logic [NUM_PINS-1:0] PIN_RST = NUM_PINS'(1 << PIN_OE);

  logic [NUM_PINS-1:0] pin_val, pin_drv, pin_sync;
  glb_ctrl_t           glb;

  always_comb begin
    pin_val         = '0;
    pin_drv         = '0;
    pin_val[PIN_PD] = pd_pin;
    pin_drv[PIN_PD] = pd_pin_drv;
    pin_val[PIN_OE] = oe_pin;
    pin_drv[PIN_OE] = oe_pin_drv;
    glb.pd_act      = pin_sync[PIN_PD];
    glb.oe_act      = pin_sync[PIN_OE];
  end

  pwr_pin_sync #(
    .NPINS  (NUM_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin_val (pin_val),
    .pin_drv (pin_drv),
    .pin_sync(pin_sync)
  );

  pwr_section_ctrl #(
    .NUM_PLL(NUM_PLL),
    .NUM_DIV(NUM_OUT)
  ) u_section (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .run_mode    (run_mode),
    .pd_act      (glb.pd_act),
    .pll_sel     (pll_pd_sel),
    .div_sel     (div_pd_sel),
    .pll_pwrdn   (pll_pwrdn),
    .div_pwrdn   (div_pwrdn),
    .osc_pwrdn   (osc_pwrdn),
    .osc_in_low  (osc_in_low),
    .osc_out_high(osc_out_high)
  );

  pwr_out_gate #(
    .NUM_OUT(NUM_OUT)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_mode (run_mode),
    .pd_act   (glb.pd_act),
    .oe_act   (glb.oe_act),
    .div_sel  (div_pd_sel),
    .force_low(clk_force_low),
    .tristate (clk_tristate)
  );

  // R3: a forced-low output belongs to a powered-down divider
  assert_force_needs_div_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clk_force_low & ~div_pwrdn) == '0);

  // R3: a powered-down divider on an enabled output is forced low
  assert_div_forces_low_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (div_pwrdn & ~clk_tristate & ~clk_force_low) == '0);

  // R8: programming mode leaves every control inactive on the next edge
  assert_prog_idle_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(run_mode) |-> (pll_pwrdn == '0 && div_pwrdn == '0 && !osc_pwrdn &&
                          clk_force_low == '0 && clk_tristate == '0));

  // R10: outputs idle during reset
  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_int_n |-> (pll_pwrdn == '0 && clk_tristate == '0 && !osc_pwrdn));

endmodule

// File: tb/pwr_gate_ctrl_bench.sv
module pwr_gate_ctrl_bench;

  localparam int unsigned NP = 3;
  localparam int unsigned NO = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          run_mode, pd_pin, pd_pin_drv, oe_pin, oe_pin_drv;
  logic [NP-1:0] pll_pd_sel;
  logic [NO-1:0] div_pd_sel;
  logic [NP-1:0] pll_pwrdn;
  logic [NO-1:0] div_pwrdn, clk_force_low, clk_tristate;
  logic          osc_pwrdn, osc_in_low, osc_out_high;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwr_gate_ctrl #(.NUM_PLL(NP), .NUM_OUT(NO)) u_pwr_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode),
    .pd_pin(pd_pin), .pd_pin_drv(pd_pin_drv),
    .oe_pin(oe_pin), .oe_pin_drv(oe_pin_drv),
    .pll_pd_sel(pll_pd_sel), .div_pd_sel(div_pd_sel),
    .pll_pwrdn(pll_pwrdn), .div_pwrdn(div_pwrdn), .osc_pwrdn(osc_pwrdn),
    .osc_in_low(osc_in_low), .osc_out_high(osc_out_high),
    .clk_force_low(clk_force_low), .clk_tristate(clk_tristate)
  );

  // All outputs packed: {pll, div, osc, in_low, out_high, force_low, tristate}
  function automatic logic [NP+3*NO+2:0] pack_out();
    return {pll_pwrdn, div_pwrdn, osc_pwrdn, osc_in_low, osc_out_high,
            clk_force_low, clk_tristate};
  endfunction

  // Independent expectation from the requirements.
  function automatic logic [NP+3*NO+2:0] model(input logic run, input logic pd_lvl,
      input logic oe_lvl, input logic [NP-1:0] ps, input logic [NO-1:0] ds);
    logic [NP-1:0] p;
    logic [NO-1:0] d, fl, ts;
    logic          o;
    p  = (run && pd_lvl) ? ps : '0;
    d  = (run && pd_lvl) ? ds : '0;
    o  = (&p) && (&d) && run && pd_lvl;
    ts = (run && !oe_lvl) ? '1 : '0;
    fl = d & ~ts;
    return {p, d, o, o, o, fl, ts};
  endfunction

  task automatic check(input string req, input logic [NP+3*NO+2:0] exp);
    checks++;
    if (pack_out() !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, pack_out(), exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic drive(input logic run, input logic pv, input logic pdrv,
      input logic ov, input logic odrv, input logic [NP-1:0] ps, input logic [NO-1:0] ds);
    run_mode = run; pd_pin = pv; pd_pin_drv = pdrv;
    oe_pin = ov; oe_pin_drv = odrv; pll_pd_sel = ps; div_pd_sel = ds;
  endtask

  task automatic t_reset();
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '1, '1);
    rst_n = 1'b0;
    wait_n(3);
    check("R10", '0);
    rst_n = 1'b1;
    wait_n(2);
    check("R10", '0);
    wait_n(4);
    check("R1", model(1, 1, 0, '1, '1));
  endtask

  task automatic t_selective();
    drive(1, 1, 1, 1, 1, 3'b010, 4'b0101);
    wait_n(4);
    check("R1", model(1, 1, 1, 3'b010, 4'b0101));
    drive(1, 0, 1, 1, 1, 3'b010, 4'b0101);
    wait_n(4);
    check("R1", '0);
  endtask

  task automatic t_pd_pullup();
    drive(1, 0, 0, 1, 1, 3'b001, 4'b1000);
    wait_n(4);
    check("R2", model(1, 1, 1, 3'b001, 4'b1000));
  endtask

  task automatic t_force_low();
    drive(1, 1, 1, 1, 1, 3'b000, 4'b0110);
    wait_n(4);
    check("R3", model(1, 1, 1, 3'b000, 4'b0110));
  endtask

  task automatic t_osc();
    drive(1, 1, 1, 1, 1, 3'b111, 4'b1111);
    wait_n(4);
    check("R4", model(1, 1, 1, '1, '1));
    pll_pd_sel = 3'b101;
    wait_n(2);
    check("R4", model(1, 1, 1, 3'b101, '1));
    pll_pd_sel = 3'b111; div_pd_sel = 4'b1110;
    wait_n(2);
    check("R4", model(1, 1, 1, '1, 4'b1110));
  endtask

  task automatic t_oe();
    drive(1, 0, 1, 0, 1, '0, '0);
    wait_n(4);
    check("R5", model(1, 0, 0, '0, '0));
    drive(1, 0, 1, 0, 0, '0, '0);
    wait_n(4);
    check("R6", '0);
  endtask

  task automatic t_priority();
    drive(1, 1, 1, 0, 1, 3'b011, 4'b1111);
    wait_n(4);
    check("R7", model(1, 1, 0, 3'b011, '1));
  endtask

  task automatic t_prog_mode();
    drive(1, 1, 1, 0, 1, '1, '1);
    wait_n(4);
    run_mode = 1'b0;
    wait_n(1);
    check("R8", '0);
    pd_pin = 1'b0; oe_pin = 1'b1;
    wait_n(1);
    pd_pin = 1'b1; oe_pin = 1'b0;
    wait_n(4);
    check("R8", '0);
  endtask

  task automatic t_latency();
    drive(1, 0, 1, 1, 1, '1, 4'b0011);
    wait_n(4);
    pd_pin = 1'b1;
    wait_n(2);
    check("R9", '0);
    wait_n(1);
    check("R9", model(1, 1, 1, '1, 4'b0011));
    div_pd_sel = 4'b1100;
    wait_n(1);
    check("R9", model(1, 1, 1, '1, 4'b1100));
    run_mode = 1'b0;
    wait_n(1);
    check("R9", '0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_selective();
        t_pd_pullup();
        t_force_low();
        t_osc();
        t_oe();
        t_priority();
        t_prog_mode();
        t_latency();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule